// File: doc/BRIEF.md
# Dual Chip-Select Access Sequencer

This block turns an already-decoded address hit into a timed access on one of two active-low chip-select lines. A set of address zones is decoded elsewhere and presented as a one-bit-per-zone hit vector. A two-bit mapping field for each zone ties that zone to select 0, to select 1, to both, or to neither. When the host side pulses a start request, the block resolves which select owns the transaction. It then drives that select low for the programmed time and reports completion with a one-cycle done pulse. A transaction whose zones belong to no select receives a one-cycle no-response pulse, and no select is driven.

Each select has its own 4-bit fixed wait count and its own enable for variable wait states. With variable wait enabled, a ready input can stretch the access cycle by cycle once the fixed count has run out. When both selects claim a transaction, select 0 always wins, and the timing settings of select 1 play no part. All timing is counted in cycles of the host-bus clock.

Top module: `dual_cs_sequencer`

## Requirements
- R1: Both chip-select outputs are active low. They are high during and after reset while no access runs, and at most one of them is low at any time.
- R2: The mapping field of zone z sits at bits [2z+1:2z] of the map input. Bit 2z assigns the zone to select 0 and bit 2z+1 assigns it to select 1. A start whose hit vector includes an assigned zone drives that zone's select.
- R3: An accepted access holds its select low for exactly 1 + N cycles, where N is that select's 4-bit fixed wait count (0 to 15).
- R4: A start that hits no zone assigned to either select drives no select. It raises no_resp_o for exactly one cycle, in the cycle after the start edge.
- R5: done_o is high for exactly one cycle, in the cycle after the select returns high.
- R6: When select 0 and select 1 both claim a transaction, only select 0 is driven and it uses select 0's timing. Select 1's wait count and variable-wait enable are ignored.
- R7: With variable wait enabled for the owning select, ready_i is sampled at each edge once the fixed count has expired. The select stays low while ready_i is low. A low ready during the fixed window has no effect.
- R8: With variable wait disabled for the owning select, ready_i has no effect on the access length.
- R9: A start that arrives from the edge that accepted an access through the cycle in which the select returns high is ignored. It changes neither select and raises no no_resp_o.
- R10: The select goes low in the cycle right after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host-bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transaction start pulse |
| zone_hit_i | input | NUM_ZONES | One bit per decoded zone hit |
| zone_map_i | input | 2*NUM_ZONES | Per-zone select assignment, two bits per zone |
| cs0_wait_i | input | WAIT_W | Fixed wait count for select 0 |
| cs0_var_en_i | input | 1 | Variable-wait enable for select 0 |
| cs1_wait_i | input | WAIT_W | Fixed wait count for select 1 |
| cs1_var_en_i | input | 1 | Variable-wait enable for select 1 |
| ready_i | input | 1 | Ready input that extends an access while low |
| cs_no | output | 2 | Chip selects, active low, bit 0 is select 0 |
| done_o | output | 1 | Access-complete pulse |
| no_resp_o | output | 1 | No-select pulse for an unclaimed start |

## Verification
With the start sampled at edge T, a select is low in cycles T+0 through T+L-1. L is 1 + N, stretched to 1 + k if ready is first seen high at the edge after cycle k. The select is high again in cycle T+L and done_o is due in cycle T+L+1. no_resp_o is due in cycle T+0 only. The bench samples every output at the falling edge of each cycle after the start and records the cycle index at which each result appears. It then compares these indices and the low-cycle counts against the values worked out from the vector fields. Ready and late start pulses are driven at falling edges, so each change takes effect at a known rising edge.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_WRAP   = 2'd2
  } dcs_state_e;
endpackage

// File: rtl/dcs_zone_resolve.sv
module dcs_zone_resolve #(
  parameter int unsigned NUM_ZONES = 4
) (
  input  logic [NUM_ZONES-1:0]   zone_hit_i,
  input  logic [2*NUM_ZONES-1:0] zone_map_i,
  output logic                   sel0_o,
  output logic                   sel1_o
);
  logic [NUM_ZONES-1:0] claim0, claim1;

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    assign claim0[z] = zone_hit_i[z] & zone_map_i[2*z];
    assign claim1[z] = zone_hit_i[z] & zone_map_i[2*z+1];
  end

  // select 0 has fixed priority
  assign sel0_o = |claim0;
  assign sel1_o = (|claim1) & ~sel0_o;
endmodule

// File: rtl/dcs_cfg_pick.sv
module dcs_cfg_pick #(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              sel0_i,
  input  logic [WAIT_W-1:0] cs0_wait_i,
  input  logic              cs0_var_en_i,
  input  logic [WAIT_W-1:0] cs1_wait_i,
  input  logic              cs1_var_en_i,
  output logic [WAIT_W-1:0] wait_o,
  output logic              var_en_o
);
  always_comb begin
    if (sel0_i) begin
      wait_o   = cs0_wait_i;
      var_en_o = cs0_var_en_i;
    end else begin
      wait_o   = cs1_wait_i;
      var_en_o = cs1_var_en_i;
    end
  end
endmodule

// File: rtl/dcs_access_timer.sv
module dcs_access_timer
  import dcs_pkg::*;
#(
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sel0_i,
  input  logic              sel1_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              var_en_i,
  input  logic              ready_i,
  output logic [1:0]        cs_act_o,
  output logic              done_o,
  output logic              no_resp_o
);
  dcs_state_e        state_q;
  logic [1:0]        cs_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              var_q;
  logic              done_q;
  logic              noresp_q;
  logic              stretch;

  assign stretch = var_q & ~ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_q     <= 2'b00;
      cnt_q    <= '0;
      var_q    <= 1'b0;
      done_q   <= 1'b0;
      noresp_q <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      noresp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (sel0_i || sel1_i) begin
              state_q <= ST_ACTIVE;
              cs_q    <= {sel1_i & ~sel0_i, sel0_i};
              cnt_q   <= wait_i;
              var_q   <= var_en_i;
            end else begin
              noresp_q <= 1'b1;
            end
          end
        end
        ST_ACTIVE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!stretch) begin
            cs_q    <= 2'b00;
            state_q <= ST_WRAP;
          end
        end
        ST_WRAP: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_act_o  = cs_q;
  assign done_o    = done_q;
  assign no_resp_o = noresp_q;

  assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_q));

  assert_fixed_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && cnt_q != '0) |=> (cs_q == $past(cs_q)));

  assert_noresp_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_resp_o |-> (cs_q == 2'b00));

  assert_done_after_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|cs_q) |=> done_o);

  assert_prio_cs0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && sel0_i) |=> (cs_q == 2'b01));

  assert_ready_stretch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && cnt_q == '0 && var_q && !ready_i) |=> (cs_q == $past(cs_q)));

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> !no_resp_o);
endmodule

// File: rtl/dual_cs_sequencer.sv
module dual_cs_sequencer #(
  parameter int unsigned NUM_ZONES = 4,
  parameter int unsigned WAIT_W    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [NUM_ZONES-1:0]   zone_hit_i,
  input  logic [2*NUM_ZONES-1:0] zone_map_i,
  input  logic [WAIT_W-1:0]      cs0_wait_i,
  input  logic                   cs0_var_en_i,
  input  logic [WAIT_W-1:0]      cs1_wait_i,
  input  logic                   cs1_var_en_i,
  input  logic                   ready_i,
  output logic [1:0]             cs_no,
  output logic                   done_o,
  output logic                   no_resp_o
);
  logic              sel0, sel1;
  logic [WAIT_W-1:0] pick_wait;
  logic              pick_var;
  logic [1:0]        cs_act;

  dcs_zone_resolve #(.NUM_ZONES(NUM_ZONES)) u_resolve (
    .zone_hit_i (zone_hit_i),
    .zone_map_i (zone_map_i),
    .sel0_o     (sel0),
    .sel1_o     (sel1)
  );

  dcs_cfg_pick #(.WAIT_W(WAIT_W)) u_pick (
    .sel0_i       (sel0),
    .cs0_wait_i   (cs0_wait_i),
    .cs0_var_en_i (cs0_var_en_i),
    .cs1_wait_i   (cs1_wait_i),
    .cs1_var_en_i (cs1_var_en_i),
    .wait_o       (pick_wait),
    .var_en_o     (pick_var)
  );

  dcs_access_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sel0_i    (sel0),
    .sel1_i    (sel1),
    .wait_i    (pick_wait),
    .var_en_i  (pick_var),
    .ready_i   (ready_i),
    .cs_act_o  (cs_act),
    .done_o    (done_o),
    .no_resp_o (no_resp_o)
  );

  assign cs_no = ~cs_act;

  assert_start_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cs_no == 2'b11 && !done_o && (sel0 || sel1) && !$past(cs_no != 2'b11))
    |=> (cs_no != 2'b11));
endmodule

// File: tb/dual_cs_sequencer_test.sv
module dual_cs_sequencer_test;
  typedef struct packed {
    logic [7:0] map;
    logic [3:0] hit;
    logic [3:0] w0;
    logic       v0;
    logic [3:0] w1;
    logic       v1;
    logic [5:0] rel;
    logic [1:0] line;
    logic [4:0] len;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 4'h1, 4'd3,  1'b0, 4'd0, 1'b0, 6'd0,  2'd0, 5'd4},
    '{8'h08, 4'h2, 4'd0,  1'b0, 4'd5, 1'b0, 6'd0,  2'd1, 5'd6},
    '{8'h01, 4'h4, 4'd2,  1'b0, 4'd2, 1'b0, 6'd0,  2'd2, 5'd0},
    '{8'hFF, 4'h0, 4'd2,  1'b0, 4'd2, 1'b0, 6'd0,  2'd2, 5'd0},
    '{8'h42, 4'h9, 4'd1,  1'b0, 4'd9, 1'b0, 6'd0,  2'd0, 5'd2},
    '{8'h03, 4'h1, 4'd0,  1'b0, 4'd7, 1'b0, 6'd0,  2'd0, 5'd1},
    '{8'h01, 4'h1, 4'd15, 1'b0, 4'd0, 1'b0, 6'd0,  2'd0, 5'd16},
    '{8'h08, 4'h2, 4'd0,  1'b0, 4'd2, 1'b1, 6'd6,  2'd1, 5'd7},
    '{8'h01, 4'h1, 4'd1,  1'b0, 4'd0, 1'b1, 6'd10, 2'd0, 5'd2},
    '{8'h08, 4'h2, 4'd0,  1'b0, 4'd4, 1'b1, 6'd0,  2'd1, 5'd5},
    '{8'h09, 4'h3, 4'd2,  1'b0, 4'd0, 1'b1, 6'd9,  2'd0, 5'd3},
    '{8'h01, 4'h1, 4'd5,  1'b1, 4'd0, 1'b0, 6'd3,  2'd0, 5'd6}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2 R3 R10 cs0 basic";
      1: return "R2 R3 cs1 basic";
      2: return "R4 unmapped zone";
      3: return "R4 no hit";
      4: return "R6 priority across zones";
      5: return "R6 priority both bits";
      6: return "R3 max wait";
      7: return "R7 ready stretch";
      8: return "R8 ready ignored";
      9: return "R7 ready high";
      10: return "R6 cs1 var cfg ignored";
      default: return "R7 low ready in fixed window";
    endcase
  endfunction

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] zone_hit_i = '0;
  logic [7:0] zone_map_i = '0;
  logic [3:0] cs0_wait_i = '0;
  logic       cs0_var_en_i = 1'b0;
  logic [3:0] cs1_wait_i = '0;
  logic       cs1_var_en_i = 1'b0;
  logic       ready_i = 1'b1;
  logic [1:0] cs_no;
  logic       done_o;
  logic       no_resp_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  dual_cs_sequencer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .zone_hit_i(zone_hit_i), .zone_map_i(zone_map_i),
    .cs0_wait_i(cs0_wait_i), .cs0_var_en_i(cs0_var_en_i),
    .cs1_wait_i(cs1_wait_i), .cs1_var_en_i(cs1_var_en_i),
    .ready_i(ready_i), .cs_no(cs_no), .done_o(done_o), .no_resp_o(no_resp_o)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // start is sampled at the next rising edge; index k counts cycles after it
  task automatic run(input vec_t v, input int inj_k, input logic [3:0] inj_hit, input string tag);
    int lo0 = 0, lo1 = 0, both = 0, dk = -1, dn = 0, nk = -1;
    int e0, e1, ed, en;
    zone_map_i = v.map; zone_hit_i = v.hit;
    cs0_wait_i = v.w0; cs0_var_en_i = v.v0;
    cs1_wait_i = v.w1; cs1_var_en_i = v.v1;
    ready_i = (v.rel == 0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (!cs_no[0]) lo0++;
      if (!cs_no[1]) lo1++;
      if (cs_no == 2'b00) both++;
      if (done_o) begin dn++; if (dk < 0) dk = k; end
      if (no_resp_o && nk < 0) nk = k;
      ready_i = (k >= int'(v.rel));
      if (k == inj_k) begin start_i = 1'b1; zone_hit_i = inj_hit; end
      else start_i = 1'b0;
      @(negedge clk_i);
    end
    e0 = (v.line == 2'd0) ? int'(v.len) : 0;
    e1 = (v.line == 2'd1) ? int'(v.len) : 0;
    ed = (v.line == 2'd2) ? -1 : int'(v.len) + 1;
    en = (v.line == 2'd2) ? 0 : -1;
    chk(lo0 == e0, tag, "cs0 low cycles", lo0, e0);
    chk(lo1 == e1, tag, "cs1 low cycles", lo1, e1);
    chk(both == 0, {tag, " R1"}, "both low cycles", both, 0);
    chk(dk == ed, {tag, " R5"}, "done index", dk, ed);
    chk(dn == ((v.line == 2'd2) ? 0 : 1), {tag, " R5"}, "done pulses", dn, (v.line == 2'd2) ? 0 : 1);
    chk(nk == en, {tag, " R4"}, "no_resp index", nk, en);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t dv;
    @(negedge clk_i);
    chk(cs_no == 2'b11, "R1 in reset", "cs_no", int'(cs_no), 3);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no == 2'b11, "R1 after reset", "cs_no", int'(cs_no), 3);
    chk(done_o == 1'b0, "R5 after reset", "done_o", int'(done_o), 0);
    chk(no_resp_o == 1'b0, "R4 after reset", "no_resp_o", int'(no_resp_o), 0);

    for (int i = 0; i < NV; i++) run(VECS[i], -1, 4'h0, tag_of(i));

    // R9: start to a cs1 zone during a cs0 access
    dv = '{8'h09, 4'h1, 4'd6, 1'b0, 4'd1, 1'b0, 6'd0, 2'd0, 5'd7};
    run(dv, 2, 4'h2, "R9 start during access");
    // R9: unclaimed start during access gives no no_resp
    run(dv, 3, 4'h0, "R9 unclaimed start during access");
    // R9: start in the cycle the select returns high
    run(dv, 6, 4'h2, "R9 start at release cycle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule